// File: doc/BRIEF.md
# Triggered Register Capture Sequencer

This block is a small bus-master engine that walks stored command programs when a trigger fires, so that the state of a chip's registers can be grabbed after a crash or on demand. Up to four programs, called lists, live in an internal command RAM. Each list is made of typed entries: reads, writes, masked read-modify-writes, and counted loops. Every value the engine reads is stored in order into an internal capture RAM. The host later reads the capture RAM back through the same host port it used to load the programs.

A trigger arrives either as a software pulse or as a crash pulse. The engine first paints the whole capture RAM with the poison word 0xDEDEDEDE. It then runs every list that is both locked and armed, in ascending list number. Each list starts from its own command base and its own capture base. The target side is a single-beat request/acknowledge master port with at most one access in flight. Each list carries its own access timeout and its own sticky status bits. Those bits feed a shared interrupt line through per-list enables.

Host map: `host_sel` 0 selects registers, 1 selects the command RAM and 2 selects the capture RAM (word index in `host_addr`). For registers, `host_addr[4:3]` is the list and `host_addr[2:0]` the field:
- 0: lock (bit 0)
- 1: config (arm in bit 9)
- 2: command base
- 3: capture base
- 4: timeout
- 5: interrupt enable (bits 2:0)
- 6: status (bits 2:0, write-one-to-clear)

Top module: `capture_sequencer`

## Requirements
- R1: After reset every list has timeout 0xFFF, and lock, arm, bases, enables and status at 0. `busy`, `irq` and `m_req` are low.
- R2: Writes to a list's arm, base or timeout fields are ignored unless its lock bit is 1. A list runs only when lock bit 0 and config bit 9 are both 1, so clearing the lock keeps it from running.
- R3: A one-cycle `sw_trig` or `crash_trig` pulse while idle raises `busy` at the next edge. The whole capture RAM is then filled with 0xDEDEDEDE before any list runs, so slots never written keep that value.
- R4: A read entry is a word with bits 31:30 = 00 and the target address in bits AW-1:0, followed by a word count in bits 15:0. It reads that many consecutive addresses, storing each value at successive capture slots from the list's capture base. A count of 0 does nothing.
- R5: A write entry is a word with bits 31:30 = 01 and the address, followed by the data word to write.
- R6: A read-modify-write entry is a word with bits 31:30 = 10 and the address, then a mask word, then a value word. It stores the old value in the next capture slot and writes back (old & ~mask) | (value & mask).
- R7: Bits 31:28 = 1100 start a loop whose count is in bits 15:0. Bits 31:28 = 1101 end the loop body, and the body runs count times. A zero count or a loop start inside a loop is illegal.
- R8: Bits 31:28 = 1110 end the list and set status bit 0.
- R9: Armed lists run in ascending list order within one trigger, so a later list sees target writes made by an earlier one.
- R10: An access with no `m_ack` after timeout+1 cycles of `m_req` is abandoned and sets status bit 1. A read or read-modify-write abandoned this way leaves its capture slot poisoned, skips any write-back, and the list continues.
- R11: An illegal entry (opcode 11 with bits 29:28 = 11, an unmatched loop end, or a bad loop start) sets status bit 2 and stops that list without setting bit 0.
- R12: Status bits are sticky and cleared by writing ones. `irq` is high while any list has a status bit set whose enable bit is also set.
- R13: Each access is one single-beat transfer. `m_req` holds address, direction and write data stable until `m_ack` or timeout, and every acknowledged access is one instruction step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_sel | input | 2 | Host region: 0 registers, 1 command RAM, 2 capture RAM |
| host_addr | input | HA | Host word address or register index |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| sw_trig | input | 1 | Software trigger pulse |
| crash_trig | input | 1 | Crash trigger pulse |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | AW | Master word address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data, valid with m_ack |
| m_ack | input | 1 | Master acknowledge |
| busy | output | 1 | Engine running |
| irq | output | 1 | Interrupt request |

## Verification
The engine is driven with a hand-built list that mixes every entry type, a two-list program where a later list reads a register written by an earlier one, and a hung target address. These separate capture ordering, list ordering, and abandon-and-continue behaviour. Malformed loops and an unlocked armed list show that bad programs stop cleanly and that gating really blocks a run. Randomised programs with random target latency and random arm masks are compared slot by slot and register by register against a bench interpreter. This exposes pointer, count and mask mistakes that the fixed cases might miss.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int AW = 16,
  parameter int CMD_DEPTH = 64,
  parameter int CAP_DEPTH = 64,
  parameter int HA = 8,
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    host_sel,
  input  logic [HA-1:0] host_addr,
  input  logic          host_wr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          sw_trig,
  input  logic          crash_trig,
  output logic          m_req,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  input  logic          m_ack,
  output logic          busy,
  output logic          irq
);
  localparam int CW = $clog2(CMD_DEPTH);
  localparam int PW = $clog2(CAP_DEPTH);
  localparam int NL = 4;
  localparam logic [31:0] POISON = 32'hDEDE_DEDE;

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_PICK, S_DEC, S_ACC} state_t;
  typedef enum logic [1:0] {K_RD, K_WR, K_RMR, K_RMW} kind_t;

  logic [31:0] cmd [CMD_DEPTH];
  logic [31:0] cap [CAP_DEPTH];

  logic          lock [NL];
  logic          arm  [NL];
  logic [CW-1:0] cbase [NL];
  logic [PW-1:0] pbase [NL];
  logic [TW-1:0] tmo  [NL];
  logic [2:0]    ien  [NL];
  logic [2:0]    ist  [NL];

  state_t        state;
  kind_t         kind;
  logic [1:0]    cur;
  logic [CW-1:0] pc, lpc;
  logic [PW-1:0] cp, fidx;
  logic [AW-1:0] maddr;
  logic [15:0]   cnt, lcnt;
  logic          in_loop;
  logic [31:0]   wd_r, mask_r, val_r;
  logic [TW-1:0] wcnt;

  wire [31:0] w  = cmd[pc];
  wire [31:0] w1 = cmd[pc + CW'(1)];
  wire [31:0] w2 = cmd[pc + CW'(2)];
  wire [1:0]  op  = w[31:30];
  wire [1:0]  sub = w[29:28];

  wire [TW-1:0] tmo_cur = tmo[cur];
  wire dec_err = state == S_DEC && op == 2'd3 &&
                 ((sub == 2'd0 && (in_loop || w[15:0] == 16'd0)) ||
                  (sub == 2'd1 && !in_loop) || sub == 2'd3);
  wire dec_end = state == S_DEC && op == 2'd3 && sub == 2'd2;
  wire acc_to  = state == S_ACC && !m_ack && wcnt == tmo_cur;
  wire [2:0] st_set = {dec_err, acc_to, dec_end};
  wire last_list = cur == 2'(NL - 1);

  wire reg_wr = host_wr && host_sel == 2'd0;
  wire [1:0] rl = host_addr[4:3];
  wire [2:0] rf = host_addr[2:0];

  assign m_req   = state == S_ACC;
  assign m_we    = kind == K_WR || kind == K_RMW;
  assign m_addr  = maddr;
  assign m_wdata = wd_r;
  assign busy    = state != S_IDLE;
  assign irq     = |(ist[0] & ien[0]) | |(ist[1] & ien[1]) |
                   |(ist[2] & ien[2]) | |(ist[3] & ien[3]);

  wire cap_we = state == S_FILL ||
                (state == S_ACC && m_ack && (kind == K_RD || kind == K_RMR));
  wire [PW-1:0] cap_wa = (state == S_FILL) ? fidx : cp;
  wire [31:0]   cap_wd = (state == S_FILL) ? POISON : m_rdata;

  always_ff @(posedge clk) begin
    if (host_wr && host_sel == 2'd1) cmd[host_addr[CW-1:0]] <= host_wdata;
    if (cap_we) cap[cap_wa] <= cap_wd;
    else if (host_wr && host_sel == 2'd2) cap[host_addr[PW-1:0]] <= host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        lock[i] <= 1'b0; arm[i] <= 1'b0; cbase[i] <= '0; pbase[i] <= '0;
        tmo[i] <= '1; ien[i] <= '0; ist[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NL; i++) begin
        if (reg_wr && rl == 2'(i)) begin
          case (rf)
            3'd0: lock[i] <= host_wdata[0];
            3'd1: if (lock[i]) arm[i] <= host_wdata[9];
            3'd2: if (lock[i]) cbase[i] <= host_wdata[CW-1:0];
            3'd3: if (lock[i]) pbase[i] <= host_wdata[PW-1:0];
            3'd4: if (lock[i]) tmo[i] <= host_wdata[TW-1:0];
            3'd5: ien[i] <= host_wdata[2:0];
            default: ;
          endcase
        end
        ist[i] <= ((reg_wr && rl == 2'(i) && rf == 3'd6) ? (ist[i] & ~host_wdata[2:0]) : ist[i])
                  | ((cur == 2'(i)) ? st_set : 3'b000);
      end
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      2'd0:
        case (rf)
          3'd0: host_rdata = {31'b0, lock[rl]};
          3'd1: host_rdata = {22'b0, arm[rl], 9'b0};
          3'd2: host_rdata = 32'(cbase[rl]);
          3'd3: host_rdata = 32'(pbase[rl]);
          3'd4: host_rdata = 32'(tmo[rl]);
          3'd5: host_rdata = {29'b0, ien[rl]};
          3'd6: host_rdata = {29'b0, ist[rl]};
          default: host_rdata = '0;
        endcase
      2'd1: host_rdata = cmd[host_addr[CW-1:0]];
      2'd2: host_rdata = cap[host_addr[PW-1:0]];
      default: host_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_RD; cur <= '0; pc <= '0; lpc <= '0;
      cp <= '0; fidx <= '0; maddr <= '0; cnt <= '0; lcnt <= '0;
      in_loop <= 1'b0; wd_r <= '0; mask_r <= '0; val_r <= '0; wcnt <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (sw_trig || crash_trig) begin
            state <= S_FILL; fidx <= '0; cur <= '0;
          end
        S_FILL: begin
          fidx <= fidx + 1'b1;
          if (fidx == PW'(CAP_DEPTH - 1)) state <= S_PICK;
        end
        S_PICK:
          if (lock[cur] && arm[cur]) begin
            pc <= cbase[cur]; cp <= pbase[cur]; in_loop <= 1'b0; state <= S_DEC;
          end else if (last_list) state <= S_IDLE;
          else cur <= cur + 2'd1;
        S_DEC: begin
          wcnt <= '0;
          case (op)
            2'd0: begin
              maddr <= w[AW-1:0]; cnt <= w1[15:0]; kind <= K_RD; pc <= pc + CW'(2);
              if (w1[15:0] != 16'd0) state <= S_ACC;
            end
            2'd1: begin
              maddr <= w[AW-1:0]; wd_r <= w1; kind <= K_WR; pc <= pc + CW'(2); state <= S_ACC;
            end
            2'd2: begin
              maddr <= w[AW-1:0]; mask_r <= w1; val_r <= w2; kind <= K_RMR;
              pc <= pc + CW'(3); state <= S_ACC;
            end
            default:
              if (dec_err || dec_end) begin
                if (last_list) state <= S_IDLE;
                else begin cur <= cur + 2'd1; state <= S_PICK; end
              end else if (sub == 2'd0) begin
                lcnt <= w[15:0]; lpc <= pc + CW'(1); in_loop <= 1'b1; pc <= pc + CW'(1);
              end else if (lcnt > 16'd1) begin
                lcnt <= lcnt - 16'd1; pc <= lpc;
              end else begin
                in_loop <= 1'b0; pc <= pc + CW'(1);
              end
          endcase
        end
        S_ACC:
          if (m_ack || acc_to) begin
            wcnt <= '0;
            case (kind)
              K_RD: begin
                cp <= cp + 1'b1; maddr <= maddr + 1'b1; cnt <= cnt - 16'd1;
                if (cnt == 16'd1) state <= S_DEC;
              end
              K_RMR: begin
                cp <= cp + 1'b1;
                if (m_ack) begin
                  kind <= K_RMW;
                  wd_r <= (m_rdata & ~mask_r) | (val_r & mask_r);
                end else state <= S_DEC;
              end
              default: state <= S_DEC;
            endcase
          end else wcnt <= wcnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module capture_sequencer_chk #(
  parameter int AW = 16,
  parameter int TW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          sw_trig,
  input logic          crash_trig,
  input logic          m_req,
  input logic          m_ack,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [31:0]   m_wdata,
  input logic          acc_to,
  input logic [1:0]    cur,
  input logic [TW-1:0] tmo_cur
);
  logic [TW:0] wait_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cnt <= '0;
    else if (!m_req || m_ack || acc_to) wait_cnt <= '0;
    else wait_cnt <= wait_cnt + 1'b1;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_req);

  // R3
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sw_trig || crash_trig));

  // R9
  list_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> cur >= $past(cur));

  // R10
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> wait_cnt <= {1'b0, tmo_cur});

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack && !acc_to) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));
endmodule

bind capture_sequencer capture_sequencer_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sw_trig(sw_trig), .crash_trig(crash_trig),
  .m_req(m_req), .m_ack(m_ack), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
  .acc_to(acc_to), .cur(cur), .tmo_cur(tmo_cur)
);

// File: tb/test_capture_sequencer.sv
module test_capture_sequencer;
  localparam int AW = 16, HA = 8, TW = 12;
  localparam logic [31:0] POISON = 32'hDEDE_DEDE;
  localparam logic [31:0] LPEND = 32'hD000_0000, LEND = 32'hE000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] host_sel = 2'd0;
  logic [HA-1:0] host_addr = '0;
  logic host_wr = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic sw_trig = 1'b0, crash_trig = 1'b0;
  logic m_req, m_we, m_ack = 1'b0, busy, irq;
  logic [AW-1:0] m_addr;
  logic [31:0] m_wdata, m_rdata = '0;

  capture_sequencer #(.AW(AW), .HA(HA), .TW(TW)) i_capture_sequencer (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_addr(host_addr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .sw_trig(sw_trig), .crash_trig(crash_trig), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .busy(busy), .irq(irq));

  logic [31:0] tmem [256];
  logic [31:0] tm   [256];
  logic [31:0] cmdm [64];
  logic [31:0] expc [64];
  bit mlock [4], marm [4];
  logic [2:0] mst [4], mien [4];
  int mcb [4], mpb [4];
  int nchk = 0, nfail = 0, lat = 0, lw = 0, hang_cnt = 0, ackn = 0, cyc = 0;

  always @(negedge clk) begin
    if (m_req && m_addr[7:0] == 8'hF0) hang_cnt++;
    if (m_ack) begin
      m_ack = 1'b0; lw = 0;
    end else if (m_req && m_addr[7:4] != 4'hF) begin
      if (lw >= lat) begin
        m_ack = 1'b1; ackn++;
        if (m_we) tmem[m_addr[7:0]] = m_wdata;
        else m_rdata = tmem[m_addr[7:0]];
        lat = $urandom % 3; lw = 0;
      end else lw++;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nchk++; nfail++;
      $display("FAIL R3 watchdog: actual busy=%0b expected idle", busy);
      summary();
    end
  end

  task automatic chk(string msg, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  task automatic wreg(int l, int f, logic [31:0] d);
    host_sel = 2'd0; host_addr = HA'(l * 8 + f); host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rreg(int l, int f, output logic [31:0] d);
    host_sel = 2'd0; host_addr = HA'(l * 8 + f); #1 d = host_rdata;
  endtask

  task automatic rcap(int a, output logic [31:0] d);
    host_sel = 2'd2; host_addr = HA'(a); #1 d = host_rdata;
  endtask

  task automatic put(inout int pos, input logic [31:0] d);
    host_sel = 2'd1; host_addr = HA'(pos % 64); host_wdata = d; host_wr = 1'b1;
    cmdm[pos % 64] = d;
    @(negedge clk); host_wr = 1'b0; pos++;
  endtask

  task automatic setup(int l, bit arm, int cb, int pb);
    wreg(l, 0, 1); mlock[l] = 1'b1;
    wreg(l, 2, cb); mcb[l] = cb;
    wreg(l, 3, pb); mpb[l] = pb;
    wreg(l, 1, arm ? 32'h200 : 32'h0); marm[l] = arm;
  endtask

  task automatic model_list(int l);
    int pc = mcb[l], cp = mpb[l], lc = 0, lpc = 0, a, n;
    bit inl = 1'b0;
    logic [31:0] w, m, v;
    for (int step = 0; step < 2000; step++) begin
      w = cmdm[pc % 64];
      a = int'(w[7:0]);
      case (w[31:30])
        2'd0: begin
          n = int'(cmdm[(pc + 1) % 64][15:0]); pc += 2;
          for (int i = 0; i < n; i++) begin
            if (a[7:4] == 4'hF) mst[l][1] = 1'b1; else expc[cp % 64] = tm[a % 256];
            cp++; a++;
          end
        end
        2'd1: begin
          v = cmdm[(pc + 1) % 64]; pc += 2;
          if (a[7:4] == 4'hF) mst[l][1] = 1'b1; else tm[a] = v;
        end
        2'd2: begin
          m = cmdm[(pc + 1) % 64]; v = cmdm[(pc + 2) % 64]; pc += 3;
          if (a[7:4] == 4'hF) mst[l][1] = 1'b1;
          else begin
            expc[cp % 64] = tm[a]; tm[a] = (tm[a] & ~m) | (v & m);
          end
          cp++;
        end
        default:
          case (w[29:28])
            2'd0: begin
              if (inl || w[15:0] == 16'd0) begin mst[l][2] = 1'b1; return; end
              lc = int'(w[15:0]); lpc = pc + 1; inl = 1'b1; pc++;
            end
            2'd1: begin
              if (!inl) begin mst[l][2] = 1'b1; return; end
              if (lc > 1) begin lc--; pc = lpc; end else begin inl = 1'b0; pc++; end
            end
            2'd2: begin mst[l][0] = 1'b1; return; end
            default: begin mst[l][2] = 1'b1; return; end
          endcase
      endcase
    end
  endtask

  task automatic run(string tag, bit crash);
    logic [31:0] d;
    int bad;
    logic [31:0] ba, be;
    logic exp_irq;
    for (int i = 0; i < 256; i++) tm[i] = tmem[i];
    for (int i = 0; i < 64; i++) expc[i] = POISON;
    for (int l = 0; l < 4; l++) if (mlock[l] && marm[l]) model_list(l);
    if (crash) crash_trig = 1'b1; else sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0; crash_trig = 1'b0;
    chk({tag, " R3 busy after trigger"}, 32'(busy), 32'd1);
    while (busy) @(negedge clk);
    bad = 0; ba = '0; be = '0;
    for (int i = 0; i < 64; i++) begin
      rcap(i, d);
      if (d !== expc[i] && bad == 0) begin ba = d; be = expc[i]; bad = 1; end
    end
    chk({tag, " R4 capture contents"}, ba, be);
    bad = 0; ba = '0; be = '0;
    for (int i = 0; i < 256; i++)
      if (tmem[i] !== tm[i] && bad == 0) begin ba = tmem[i]; be = tm[i]; bad = 1; end
    chk({tag, " R6 target registers"}, ba, be);
    exp_irq = 1'b0;
    for (int l = 0; l < 4; l++) begin
      rreg(l, 6, d);
      chk({tag, " R8 status"}, d, 32'(mst[l]));
      exp_irq |= |(mst[l] & mien[l]);
    end
    chk({tag, " R12 irq"}, 32'(irq), 32'(exp_irq));
    @(negedge clk);
  endtask

  task automatic clear_status();
    for (int l = 0; l < 4; l++) begin wreg(l, 6, 7); mst[l] = '0; end
  endtask

  task automatic gen(int l);
    int pos = l * 16;
    int nops = 1 + int'($urandom % 3);
    logic [31:0] a;
    for (int k = 0; k < nops; k++) begin
      a = $urandom % 64;
      case ($urandom % 4)
        0: begin put(pos, a); put(pos, 1 + $urandom % 2); end
        1: begin put(pos, 32'h4000_0000 | a); put(pos, $urandom); end
        2: begin put(pos, 32'h8000_0000 | a); put(pos, $urandom); put(pos, $urandom); end
        default: begin
          put(pos, 32'hC000_0000 | (1 + $urandom % 2));
          put(pos, a); put(pos, 1 + $urandom % 2); put(pos, LPEND);
        end
      endcase
    end
    put(pos, LEND);
  endtask

  initial begin
    logic [31:0] d, old30;
    int pos;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) tmem[i] = $urandom;
    for (int l = 0; l < 4; l++) begin
      mlock[l] = 0; marm[l] = 0; mst[l] = '0; mien[l] = '0; mcb[l] = 0; mpb[l] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 m_req", 32'(m_req), 0);
    for (int l = 0; l < 4; l++) begin
      rreg(l, 4, d); chk("R1 timeout default", d, 32'hFFF);
      rreg(l, 0, d); chk("R1 lock", d, 0);
      rreg(l, 6, d); chk("R1 status", d, 0);
    end

    // R2 gating without lock
    wreg(0, 1, 32'h200); rreg(0, 1, d); chk("R2 arm ignored unlocked", d, 0);
    wreg(0, 2, 5); rreg(0, 2, d); chk("R2 base ignored unlocked", d, 0);

    // R4 R5 R6 R7 R8 directed mixed program on list 0
    tmem[8'h21] = 32'hFFFF_FF05;
    pos = 0;
    put(pos, 32'h0000_0010); put(pos, 3);
    put(pos, 32'h4000_0020); put(pos, 32'h1234_5678);
    put(pos, 32'h8000_0021); put(pos, 32'hF); put(pos, 32'hA);
    put(pos, 32'hC000_0002); put(pos, 32'h0000_0030); put(pos, 1); put(pos, LPEND);
    put(pos, LEND);
    setup(0, 1, 0, 0);
    wreg(0, 5, 1); mien[0] = 3'b001;
    ackn = 0;
    run("mixed", 0);
    rcap(3, d); chk("R6 captured old value", d, 32'hFFFF_FF05);
    chk("R6 masked write-back", tmem[8'h21], 32'hFFFF_FF0A);
    chk("R5 write data", tmem[8'h20], 32'h1234_5678);
    rcap(5, d); chk("R7 second loop pass", d, tmem[8'h30]);
    rcap(6, d); chk("R3 unused slot poisoned", d, POISON);
    chk("R13 acknowledged access count", 32'(ackn), 32'd8);
    chk("R12 irq on finish", 32'(irq), 1);
    wreg(0, 6, 1); mst[0] = '0;
    chk("R12 irq after clear", 32'(irq), 0);
    wreg(0, 5, 0); mien[0] = '0;

    // R9 list order
    pos = 0;
    put(pos, 32'h0000_0005); put(pos, 1);
    put(pos, 32'h4000_0005); put(pos, 32'h0000_0111); put(pos, LEND);
    pos = 32;
    put(pos, 32'h0000_0005); put(pos, 1); put(pos, LEND);
    setup(2, 1, 32, 32);
    run("order", 0);
    rcap(32, d); chk("R9 later list sees earlier write", d, 32'h111);
    clear_status();

    // R10 timeout on list 1
    wreg(0, 1, 0); marm[0] = 0; wreg(2, 1, 0); marm[2] = 0;
    pos = 16;
    put(pos, 32'h0000_00F0); put(pos, 1);
    put(pos, 32'h0000_0010); put(pos, 1); put(pos, LEND);
    setup(1, 1, 16, 16);
    wreg(1, 4, 4);
    wreg(1, 5, 2); mien[1] = 3'b010;
    hang_cnt = 0;
    run("timeout", 0);
    chk("R10 request cycles before abandon", 32'(hang_cnt), 32'd5);
    rcap(16, d); chk("R10 abandoned slot poisoned", d, POISON);
    rcap(17, d); chk("R10 list continues", d, tmem[8'h10]);
    wreg(1, 6, 1); rreg(1, 6, d);
    chk("R12 write-one clears only bit 0", d, 32'd2);
    chk("R12 irq held by bit 1", 32'(irq), 1);
    wreg(1, 6, 2); chk("R12 irq released", 32'(irq), 0);
    mst[1] = '0; mien[1] = '0; wreg(1, 5, 0);
    wreg(1, 4, 32'hFFF); wreg(1, 1, 0); marm[1] = 0;

    // R11 illegal entries on list 3, crash trigger
    old30 = tmem[8'h30];
    pos = 48;
    put(pos, LPEND); put(pos, 32'h4000_0030); put(pos, 32'h55); put(pos, LEND);
    setup(3, 1, 48, 48);
    run("unmatched end", 1);
    chk("R11 no write after illegal entry", tmem[8'h30], old30);
    clear_status();
    pos = 48;
    put(pos, 32'hC000_0000); put(pos, 32'h0000_0001); put(pos, 1); put(pos, LPEND); put(pos, LEND);
    run("zero loop", 1);
    rcap(48, d); chk("R11 zero count runs nothing", d, POISON);
    clear_status();
    pos = 48;
    put(pos, 32'hC000_0002); put(pos, 32'hC000_0001); put(pos, LEND);
    run("nested loop", 0);
    clear_status();
    pos = 48;
    put(pos, 32'hF000_0000); put(pos, LEND);
    run("bad opcode", 0);
    clear_status();

    // R2 clearing the lock keeps an armed list idle
    pos = 48;
    put(pos, 32'h4000_0031); put(pos, 32'h77); put(pos, LEND);
    old30 = tmem[8'h31];
    wreg(3, 0, 0); mlock[3] = 0;
    run("unlocked", 0);
    chk("R2 unlocked list does not run", tmem[8'h31], old30);

    // R4 R6 R7 R9 randomised programs
    for (int r = 0; r < 20; r++) begin
      int am;
      am = 1 + int'($urandom % 15);
      for (int l = 0; l < 4; l++) begin
        setup(l, am[l], l * 16, l * 16);
        gen(l);
      end
      run("random", r[0]);
      clear_status();
    end

    summary();
  end
endmodule